// File: doc/BRIEF.md
# Prioritised Interrupt Pending and Active Tracker

This block keeps two state bits for each of a parameterised number of interrupt lines. The pending bit records that a line has asked for service. The active bit records that its handler has been entered and has not yet returned. From these bits and the per-line enables and priorities, the block chooses the next line to service. It also computes the execution priority of the handler that is currently running. It raises a take request when the chosen line is allowed to preempt that priority.

Priority values are unsigned and numerically smaller means more urgent, so 0 is the most urgent level. The execution priority is one bit wider than a line priority. When no handler is running it sits at the idle value 2^PRIO_W, which any enabled pending line beats.

A core-side sequencer drives `ack` when it enters the handler that the block offers. It drives `ret` together with `ret_id` when a handler finishes. Software strobes can force a pending bit on or off. Pending and active are independent bits, so a line can be waiting and running at the same time. A request that arrives during its own handler is therefore serviced again after return.

Top module: `irq_tracker`

## Requirements
- R1: A request input that is high for one or more cycles sets that line's pending bit at the next clock edge, so a held level and a single-cycle pulse both work. A `sw_set` strobe bit sets the pending bit in the same way.
- R2: A `ret` strobe clears only the active bit of line `ret_id` and leaves its pending bit alone. If that line is still pending and enabled, `take_req` rises in the next cycle with that line as the winner.
- R3: If a request arrives after `sw_clr` has cleared a line that is still active, the line becomes pending and active at once, and it is taken after its return.
- R4: `take_req` is high only when a winner exists and its priority value is strictly smaller than `exec_prio`.
- R5: A pending line whose priority is equal to or less urgent than `exec_prio` is kept pending, not dropped. It is taken once `exec_prio` relaxes.
- R6: The winner is the enabled pending line with the smallest priority value. `win_valid` is low when no enabled line is pending.
- R7: Among enabled pending lines that share the smallest priority value, the lowest line number wins.
- R8: At a clock edge where `ack` and `take_req` are both high, the winner's pending bit clears and its active bit sets. A request or `sw_set` on the winner in that same cycle keeps the pending bit set. An `ack` while `take_req` is low changes nothing.
- R9: `exec_prio` is the smallest priority value among active lines, or 2^PRIO_W when no line is active.
- R10: A line with its enable low still collects a pending bit but is never the winner.
- R11: A `sw_clr` bit clears the pending bit. When a set source (request or `sw_set`) is present in the same cycle, the set wins.
- R12: After reset, all pending and active bits are 0, `take_req` and `win_valid` are low, and `exec_prio` is 2^PRIO_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | NUM_LINES | Raw request per line, level or pulse |
| irq_en | input | NUM_LINES | Per-line enable for selection |
| irq_prio | input | NUM_LINES*PRIO_W | Packed priorities, line i at bits [i*PRIO_W +: PRIO_W], 0 most urgent |
| sw_set | input | NUM_LINES | Software set-pending strobes |
| sw_clr | input | NUM_LINES | Software clear-pending strobes |
| ack | input | 1 | Handler entry for the offered winner |
| ret | input | 1 | Handler return strobe |
| ret_id | input | IDX_W | Line whose handler returns |
| win_valid | output | 1 | An enabled line is pending |
| win_id | output | IDX_W | Winning line number |
| win_prio | output | PRIO_W | Winning line priority |
| take_req | output | 1 | Winner may preempt the current execution priority |
| exec_prio | output | PRIO_W+1 | Current execution priority |
| pend_o | output | NUM_LINES | Pending bits |
| act_o | output | NUM_LINES | Active bits |

## Verification
Directed sequences exercise specific behaviours one at a time. A pulse followed by entry and return shows that return leaves the pending bit alone. A re-request during the handler separates pending-and-active from a plain clear. Nested entries of unequal and equal priority check that preemption requires a strictly more urgent winner. Two lines that share a priority, and the same pair with one line disabled, check the tie-break and the enable gating. A long run follows in which request levels, pulses, software strobes, enables, priorities from a narrow range (so ties occur often), entries and returns are drawn at random. Every cycle in that run is compared against a bench model of the pending and active sets, which catches errors that appear only in rare combinations of overlapping events.

// File: rtl/irq_trk_pkg.sv
// Package: shared defaults for the interrupt tracker.
// Assumes: consumers take these as parameter defaults only.
package irq_trk_pkg;
    localparam int DEF_LINES  = 8;
    localparam int DEF_PRIO_W = 3;
endpackage

// File: rtl/irq_line_bank.sv
// Module: per-line pending and active state registers.
// Does: sets pending from request/software, clears it on software clear
// or handler entry (set wins), sets active on entry, clears on return.
// Assumes: take_hit is one-hot or zero; reset is synchronous, active low.
module irq_line_bank #(
    parameter int NUM_LINES = irq_trk_pkg::DEF_LINES,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req,
    input  logic [NUM_LINES-1:0] sw_set,
    input  logic [NUM_LINES-1:0] sw_clr,
    input  logic [NUM_LINES-1:0] take_hit,
    input  logic                 ret,
    input  logic [IDX_W-1:0]     ret_id,
    output logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] act
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [IDX_W-1:0] MY_ID = IDX_W'(g);
        logic ret_hit;
        logic set_any;

        // Decode whether this line's handler returns now.
        assign ret_hit = ret && (ret_id == MY_ID);
        // Any source that asks for pending this cycle.
        assign set_any = req[g] | sw_set[g];

        // Pending register: set sources override clear sources.
        always_ff @(posedge clk) begin
            if (!rst_n) pend[g] <= 1'b0;
            else        pend[g] <= (pend[g] & ~(sw_clr[g] | take_hit[g])) | set_any;
        end

        // Active register: entry overrides return on the same line.
        always_ff @(posedge clk) begin
            if (!rst_n) act[g] <= 1'b0;
            else        act[g] <= (act[g] & ~ret_hit) | take_hit[g];
        end

        assert_ret_keeps_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_hit && pend[g] && !sw_clr[g] && !take_hit[g]) |=> pend[g]);

        assert_entry_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
            take_hit[g] |=> (act[g] && (pend[g] == ($past(req[g]) | $past(sw_set[g])))));

        assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (req[g] || sw_set[g]) |=> pend[g]);
    end
endmodule

// File: rtl/irq_arbiter.sv
// Module: selects the enabled pending line with the most urgent priority.
// Does: smallest priority value wins; ties go to the lower line number.
// Assumes: priorities are packed PRIO_W-bit fields, 0 most urgent.
module irq_arbiter #(
    parameter int NUM_LINES = irq_trk_pkg::DEF_LINES,
    parameter int PRIO_W    = irq_trk_pkg::DEF_PRIO_W,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        pend,
    input  logic [NUM_LINES-1:0]        en,
    input  logic [NUM_LINES*PRIO_W-1:0] prio,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_id,
    output logic [PRIO_W-1:0]           win_prio
);
    logic [NUM_LINES-1:0] cand;

    // Only enabled pending lines compete.
    assign cand = pend & en;

    // Scan from the top line down so an equal priority lets the lower index replace.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '1;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i] && (!win_valid || prio[i*PRIO_W +: PRIO_W] <= win_prio)) begin
                win_valid = 1'b1;
                win_id    = IDX_W'(i);
                win_prio  = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assert_winner_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (pend[win_id] && en[win_id]));

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        assert_winner_most_urgent_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cand[g] |-> (win_valid && win_prio <= prio[g*PRIO_W +: PRIO_W]));
        assert_tie_low_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cand[g] && prio[g*PRIO_W +: PRIO_W] == win_prio) |-> (int'(win_id) <= g));
    end
endmodule

// File: rtl/irq_exec_level.sv
// Module: current execution priority from the active set.
// Does: minimum priority over active lines, or 2^PRIO_W when idle.
// Assumes: result is one bit wider than a line priority.
module irq_exec_level #(
    parameter int NUM_LINES = irq_trk_pkg::DEF_LINES,
    parameter int PRIO_W    = irq_trk_pkg::DEF_PRIO_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        act,
    input  logic [NUM_LINES*PRIO_W-1:0] prio,
    output logic [PRIO_W:0]             exec_prio
);
    localparam logic [PRIO_W:0] IDLE_LVL = {1'b1, {PRIO_W{1'b0}}};

    // Minimum search over the active lines.
    always_comb begin
        exec_prio = IDLE_LVL;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (act[i] && ({1'b0, prio[i*PRIO_W +: PRIO_W]} < exec_prio))
                exec_prio = {1'b0, prio[i*PRIO_W +: PRIO_W]};
        end
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        assert_exec_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
            act[g] |-> (exec_prio <= {1'b0, prio[g*PRIO_W +: PRIO_W]}));
    end
endmodule

// File: rtl/irq_tracker.sv
// Module: top of the prioritised interrupt pending/active tracker.
// Does: combines line state, winner selection and execution priority,
// raises take_req when the winner strictly beats the running level,
// and commits handler entry on ack.
// Assumes: NUM_LINES >= 2; ret_id names a line; synchronous active-low reset.
module irq_tracker #(
    parameter int NUM_LINES = irq_trk_pkg::DEF_LINES,
    parameter int PRIO_W    = irq_trk_pkg::DEF_PRIO_W,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        irq_req,
    input  logic [NUM_LINES-1:0]        irq_en,
    input  logic [NUM_LINES*PRIO_W-1:0] irq_prio,
    input  logic [NUM_LINES-1:0]        sw_set,
    input  logic [NUM_LINES-1:0]        sw_clr,
    input  logic                        ack,
    input  logic                        ret,
    input  logic [IDX_W-1:0]            ret_id,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_id,
    output logic [PRIO_W-1:0]           win_prio,
    output logic                        take_req,
    output logic [PRIO_W:0]             exec_prio,
    output logic [NUM_LINES-1:0]        pend_o,
    output logic [NUM_LINES-1:0]        act_o
);
    logic [NUM_LINES-1:0] take_hit;
    logic                 go;

    irq_line_bank #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .req(irq_req), .sw_set(sw_set), .sw_clr(sw_clr),
        .take_hit(take_hit), .ret(ret), .ret_id(ret_id), .pend(pend_o), .act(act_o)
    );

    irq_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(pend_o), .en(irq_en), .prio(irq_prio),
        .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio)
    );

    irq_exec_level #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_exec (
        .clk(clk), .rst_n(rst_n), .act(act_o), .prio(irq_prio), .exec_prio(exec_prio)
    );

    // Preemption needs a strictly more urgent winner.
    assign take_req = win_valid && ({1'b0, win_prio} < exec_prio);
    // Entry only commits while a take is offered.
    assign go = ack && take_req;

    // One-hot entry strobe toward the winning line.
    always_comb begin
        take_hit = '0;
        if (go) take_hit[win_id] = 1'b1;
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
        assert_preempt_strict_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (take_req && act_o[g]) |-> (win_prio < irq_prio[g*PRIO_W +: PRIO_W]));
    end

    assert_ack_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !take_req && !ret) |=> (act_o == $past(act_o)));

    assert_entry_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_hit));
endmodule

// File: tb/irq_tracker_bench.sv
module irq_tracker_bench;
    localparam int N  = 8;
    localparam int PW = 3;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic [N-1:0] irq_req, irq_en, sw_set, sw_clr;
    logic [N*PW-1:0] irq_prio;
    logic ack, ret;
    logic [IW-1:0] ret_id;
    logic win_valid, take_req;
    logic [IW-1:0] win_id;
    logic [PW-1:0] win_prio;
    logic [PW:0] exec_prio;
    logic [N-1:0] pend_o, act_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [N-1:0] m_pend, m_act;

    always #5 clk = ~clk;

    irq_tracker #(.NUM_LINES(N), .PRIO_W(PW)) u_irq_tracker (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .irq_prio(irq_prio),
        .sw_set(sw_set), .sw_clr(sw_clr), .ack(ack), .ret(ret), .ret_id(ret_id),
        .win_valid(win_valid), .win_id(win_id), .win_prio(win_prio), .take_req(take_req),
        .exec_prio(exec_prio), .pend_o(pend_o), .act_o(act_o)
    );

    task automatic chk(string tag, string what, int actual, int expected);
        n_chk++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
        end
    endtask

    function automatic int pr(int i);
        return int'(irq_prio[i*PW +: PW]);
    endfunction

    // Expected winner from the model state.
    function automatic void model_sel(output bit v, output int id, output int p);
        v = 0; id = 0; p = 0;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && irq_en[i] && (!v || pr(i) < p)) begin
                v = 1; id = i; p = pr(i);
            end
    endfunction

    function automatic int model_exec();
        int e = 1 << PW;
        for (int i = 0; i < N; i++)
            if (m_act[i] && pr(i) < e) e = pr(i);
        return e;
    endfunction

    // One cycle: drive, compare outputs to the model, advance the model, release strobes.
    task automatic step(string tag, logic [N-1:0] rq, logic [N-1:0] st, logic [N-1:0] cl,
                        logic ak, logic rt, int rid);
        bit v; int id; int p; int e; bit tk; bit go;
        @(negedge clk);
        irq_req = rq; sw_set = st; sw_clr = cl; ack = ak; ret = rt; ret_id = IW'(rid);
        #1;
        model_sel(v, id, p);
        e  = model_exec();
        tk = v && (p < e);
        chk(tag, "win_valid", int'(win_valid), int'(v));
        if (v) begin
            chk(tag, "win_id", int'(win_id), id);
            chk(tag, "win_prio", int'(win_prio), p);
        end
        chk(tag, "exec_prio", int'(exec_prio), e);
        chk(tag, "take_req", int'(take_req), int'(tk));
        chk(tag, "pend", int'(pend_o), int'(m_pend));
        chk(tag, "act", int'(act_o), int'(m_act));
        go = ak && tk;
        for (int i = 0; i < N; i++) begin
            bit hit = go && (id == i);
            m_pend[i] = (m_pend[i] & ~(cl[i] | hit)) | rq[i] | st[i];
            m_act[i]  = (m_act[i] & ~(rt && rid == i)) | hit;
        end
        @(posedge clk); #1;
        irq_req = '0; sw_set = '0; sw_clr = '0; ack = 0; ret = 0;
    endtask

    // Look at the outputs one idle cycle later (state holds with no inputs).
    task automatic look();
        @(negedge clk); #1;
    endtask

    function automatic void set_pr(int i, int p);
        irq_prio[i*PW +: PW] = PW'(p);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd4242));
        rst_n = 0; irq_req = '0; irq_en = '1; sw_set = '0; sw_clr = '0;
        ack = 0; ret = 0; ret_id = '0; irq_prio = '0;
        m_pend = '0; m_act = '0;
        for (int i = 0; i < N; i++) set_pr(i, 7);
        repeat (3) @(posedge clk);
        #1; rst_n = 1;
        look();
        // R12 reset state
        chk("R12", "pend", int'(pend_o), 0);
        chk("R12", "act", int'(act_o), 0);
        chk("R12", "take_req", int'(take_req), 0);
        chk("R12", "win_valid", int'(win_valid), 0);
        chk("R12", "exec_prio", int'(exec_prio), 8);

        // R1 single pulse on line 2
        set_pr(2, 5);
        step("R1", 8'h04, 0, 0, 0, 0, 0);
        look();
        chk("R1", "pend2", int'(pend_o[2]), 1);
        chk("R1", "take_req", int'(take_req), 1);
        chk("R1", "win_id", int'(win_id), 2);
        // R8 entry
        step("R8", 0, 0, 0, 1, 0, 0);
        look();
        chk("R8", "act2", int'(act_o[2]), 1);
        chk("R8", "pend2", int'(pend_o[2]), 0);
        chk("R9", "exec_prio", int'(exec_prio), 5);
        // R3 re-request while own handler runs
        step("R3", 8'h04, 0, 0, 0, 0, 0);
        look();
        chk("R3", "pend2", int'(pend_o[2]), 1);
        chk("R3", "act2", int'(act_o[2]), 1);
        chk("R5", "take_req equal prio", int'(take_req), 0);
        // R2 return keeps pending, taken again
        step("R2", 0, 0, 0, 0, 1, 2);
        look();
        chk("R2", "act2", int'(act_o[2]), 0);
        chk("R2", "pend2", int'(pend_o[2]), 1);
        chk("R2", "take_req", int'(take_req), 1);
        step("R8", 0, 0, 0, 1, 0, 0);
        // R5 equal priority line 6 held
        set_pr(6, 5);
        step("R5", 8'h40, 0, 0, 0, 0, 0);
        look();
        chk("R5", "take_req", int'(take_req), 0);
        chk("R5", "pend6", int'(pend_o[6]), 1);
        // R4 more urgent line 1 preempts
        set_pr(1, 3);
        step("R4", 8'h02, 0, 0, 0, 0, 0);
        look();
        chk("R4", "take_req", int'(take_req), 1);
        chk("R6", "win_id", int'(win_id), 1);
        step("R4", 0, 0, 0, 1, 0, 0);
        look();
        chk("R9", "exec nested", int'(exec_prio), 3);
        step("R9", 0, 0, 0, 0, 1, 1);
        look();
        chk("R9", "exec after ret", int'(exec_prio), 5);
        chk("R5", "still held", int'(take_req), 0);
        step("R5", 0, 0, 0, 0, 1, 2);
        look();
        chk("R5", "taken after drop", int'(take_req), 1);
        chk("R5", "win_id", int'(win_id), 6);
        // R7 tie and R10 disable
        step("R11", 0, 0, 8'hFF, 0, 0, 0);
        set_pr(4, 2); set_pr(5, 2);
        step("R7", 0, 8'h30, 0, 0, 0, 0);
        look();
        chk("R7", "win_id tie", int'(win_id), 4);
        irq_en[4] = 0;
        look();
        chk("R10", "win_id disabled skipped", int'(win_id), 5);
        chk("R10", "pend4 kept", int'(pend_o[4]), 1);
        irq_en = '0;
        step("R10", 8'h01, 0, 0, 0, 0, 0);
        look();
        chk("R10", "no winner", int'(win_valid), 0);
        chk("R10", "pend0", int'(pend_o[0]), 1);
        irq_en = '1;
        // R11 set wins over clear, clear alone clears
        step("R11", 0, 8'h01, 8'h01, 0, 0, 0);
        look();
        chk("R11", "set wins", int'(pend_o[0]), 1);
        step("R11", 0, 0, 8'hFF, 0, 0, 0);
        look();
        chk("R11", "cleared", int'(pend_o), 0);
        // R8 ack without take ignored
        step("R8", 0, 0, 0, 1, 0, 0);
        look();
        chk("R8", "ack ignored act", int'(act_o[0]), int'(m_act[0]));
        // R8 ack with simultaneous request on winner
        set_pr(3, 1);
        step("R8", 8'h08, 0, 0, 0, 0, 0);
        step("R8", 8'h08, 0, 0, 1, 0, 0);
        look();
        chk("R8", "act3", int'(act_o[3]), 1);
        chk("R8", "pend3 re-set", int'(pend_o[3]), 1);

        // Random phase, R1 R2 R4 R6 R7 R9 R11 compared every cycle against the model
        begin
            logic [N-1:0] held = '0;
            for (int c = 0; c < 4000; c++) begin
                logic [N-1:0] rq, st, cl;
                if (c % 64 == 0) begin
                    for (int i = 0; i < N; i++) set_pr(i, int'($urandom_range(0, 3)));
                    irq_en = N'($urandom) | N'($urandom);
                end
                if ($urandom_range(0, 9) == 0) held = N'($urandom) & N'($urandom) & N'($urandom);
                rq = held;
                for (int i = 0; i < N; i++) if ($urandom_range(0, 15) == 0) rq[i] = 1;
                st = ($urandom_range(0, 7) == 0) ? N'(1 << $urandom_range(0, N-1)) : '0;
                cl = ($urandom_range(0, 5) == 0) ? N'($urandom) : '0;
                step("R6", rq, st, cl, $urandom_range(0, 1) == 1,
                     $urandom_range(0, 3) == 0, int'($urandom_range(0, N-1)));
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule